// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Port

This block is an eight-bit peripheral port placed next to a microcontroller whose low address byte and data share one bus. Each pin can be a plain input or output with its own direction and data bits, or it can present the matching bit of the low address byte captured from the bus. Each pin can also be push-pull or open-drain. The CPU configures the port and reads it back through a small register window. It selects that window with an externally decoded register select, a three-bit offset and the active-low read and write strobes.

One control bit puts the whole port into track mode. In this mode the port is a bidirectional buffer between the bus and the pins, steered by three externally decoded selects (address-out, data-out, data-in) together with ALE and the strobes. When none of those paths is active, the pins float. All inputs are sampled on the rising edge of `clk`. The track-mode paths are combinational from the selects and strobes.

Top module: `mux_bus_port`

## Requirements
- R1: After a synchronous active-low reset, every configuration and data register is 0. All pins are released (`pin_oe` = 0), `ad_oe` is 0, and track mode is off.
- R2: Outside track mode, a pin whose address-mode bit is 0 drives its data-register bit when its direction bit is 1 and is released when its direction bit is 0.
- R3: While `reg_sel` is 1 and `rd_n` is 0, `ad_out` returns the register at `reg_addr` and `ad_oe` is 1. The offsets are: 0 direction, 1 data, 2 live `pin_in` levels, 3 address-mode bits, 4 open-drain bits, 5 control (bit 0 = track mode). Offsets 6 and 7 read as 0.
- R4: A register write takes the `ad_in` value and offset held in the last cycle that `wr_n` was 0 with `reg_sel` at 1. It commits in the cycle `wr_n` is first seen high again, and the outputs reflect it one clock later. Offset 2 is read-only.
- R5: Outside track mode, on a pin whose open-drain bit is 1, an output value of 1 releases the pin and a value of 0 drives it low. This applies to both data and address output values.
- R6: The address latch takes the `ad_in` value of the last cycle ALE was high, at the first cycle ALE is seen low. A pin whose address-mode bit is 1 drives latch bit n whatever its direction bit, and keeps the previous latch value until the fall.
- R7: In track mode, while `sel_addr_out` and `ale` are both 1, all pins drive `ad_in`.
- R8: In track mode, while `sel_data_out` is 1 and `wr_n` is 0, all pins drive `ad_in`.
- R9: In track mode, while `sel_data_in` is 1 and `rd_n` is 0, with no register read in progress, `ad_out` equals `pin_in` and `ad_oe` is 1.
- R10: In track mode, pins are push-pull and ignore the direction, data, address-mode and open-drain bits. They are all released when neither the R7 nor the R8 condition holds.
- R11: `ad_oe` is 1 only for a register read (R3) or a track-mode data-in read (R9). A data-in select outside track mode leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ale | input | 1 | Address latch enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| reg_sel | input | 1 | Decoded select of the port register window |
| reg_addr | input | 3 | Register offset |
| sel_addr_out | input | 1 | Track-mode address-out select |
| sel_data_out | input | 1 | Track-mode data-out select |
| sel_data_in | input | 1 | Track-mode data-in select |
| ad_in | input | 8 | Value on the multiplexed bus |
| ad_out | output | 8 | Value the port puts on the bus |
| ad_oe | output | 1 | Bus drive enable |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
The assertions assume that a register read and a track-mode data-in read never overlap. They also assume the decoded selects change only between clock edges, and that ALE is held for at least one sampled cycle before it falls. The stimulus follows these rules. Each bus transfer is a task that raises one select or strobe at a time, holds ALE and the write strobe for two clocks, and changes inputs only shortly after a rising edge. A behavioural model in the bench predicts every output on every cycle from the same inputs.

// File: rtl/mbp_pkg.sv
// Package: shared register offsets for the multiplexed-bus peripheral port.
// Assumes a three-bit offset space; unused offsets read as zero.
package mbp_pkg;
    localparam int OFF_W = 3;
    typedef enum logic [OFF_W-1:0] {
        OFF_DIR   = 3'd0,
        OFF_DATA  = 3'd1,
        OFF_PINS  = 3'd2,
        OFF_AMODE = 3'd3,
        OFF_ODRN  = 3'd4,
        OFF_CTRL  = 3'd5
    } reg_off_e;
endpackage

// File: rtl/mbp_regs.sv
// Module: configuration and data registers of the port.
// A write is captured while wr_n is low and committed on the first cycle
// wr_n is sampled high again. Assumes strobes are synchronous to clk.
module mbp_regs
    import mbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic             wr_n,
    input  logic [W-1:0]     ad_in,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     data_q,
    output logic [W-1:0]     amode_q,
    output logic [W-1:0]     od_q,
    output logic             track_q
);
    logic             wr_n_d;
    logic             sel_hold;
    logic [OFF_W-1:0] off_hold;
    logic [W-1:0]     val_hold;
    logic             commit;

    // Purpose: detect the end of a selected write cycle.
    always_comb commit = wr_n && !wr_n_d && sel_hold;

    // Purpose: hold the offset and data seen during the low strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_d   <= 1'b1;
            sel_hold <= 1'b0;
            off_hold <= '0;
            val_hold <= '0;
        end else begin
            wr_n_d <= wr_n;
            if (!wr_n) begin
                sel_hold <= reg_sel;
                off_hold <= reg_addr;
                val_hold <= ad_in;
            end
        end
    end

    // Purpose: update the addressed register when a write commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            data_q  <= '0;
            amode_q <= '0;
            od_q    <= '0;
            track_q <= 1'b0;
        end else if (commit) begin
            case (off_hold)
                OFF_DIR:   dir_q   <= val_hold;
                OFF_DATA:  data_q  <= val_hold;
                OFF_AMODE: amode_q <= val_hold;
                OFF_ODRN:  od_q    <= val_hold;
                OFF_CTRL:  track_q <= val_hold[0];
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/mbp_addr_latch.sv
// Module: low address byte latch.
// Follows the bus while ALE is high into a shadow; the visible latch
// takes the shadow at the first cycle ALE is sampled low.
module mbp_addr_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ale,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] addr_q
);
    logic         ale_d;
    logic [W-1:0] shadow;

    // Purpose: track the bus during ALE and commit on its trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_d  <= 1'b0;
            shadow <= '0;
            addr_q <= '0;
        end else begin
            ale_d <= ale;
            if (ale)
                shadow <= ad_in;
            if (ale_d && !ale)
                addr_q <= shadow;
        end
    end
endmodule

// File: rtl/mbp_pin_drive.sv
// Module: per-pin output selection and drive enable.
// Combinational. Track mode overrides the I/O, address and open-drain
// settings; trk_drive says whether a track path is currently active.
module mbp_pin_drive #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] amode_q,
    input  logic [W-1:0] od_q,
    input  logic [W-1:0] addr_q,
    input  logic         track_q,
    input  logic         trk_drive,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar n = 0; n < W; n++) begin : g_pin
        logic val;
        logic en;

        // Purpose: pick the value and enable for this pin in I/O or address mode.
        always_comb begin
            val = amode_q[n] ? addr_q[n] : data_q[n];
            en  = amode_q[n] | dir_q[n];
        end

        // Purpose: apply track override and open-drain shaping.
        always_comb begin
            if (track_q) begin
                pin_oe[n]  = trk_drive;
                pin_out[n] = ad_in[n];
            end else if (od_q[n]) begin
                pin_oe[n]  = en & ~val;
                pin_out[n] = 1'b0;
            end else begin
                pin_oe[n]  = en;
                pin_out[n] = val;
            end
        end
    end
endmodule

// File: rtl/mux_bus_port.sv
// Module: top of the multiplexed-bus peripheral port.
// Assumes address decoding is external (reg_sel and the three track
// selects) and that pads combine pin_out/pin_oe and ad_out/ad_oe.
module mux_bus_port
    import mbp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             reg_sel,
    input  logic [OFF_W-1:0] reg_addr,
    input  logic             sel_addr_out,
    input  logic             sel_data_out,
    input  logic             sel_data_in,
    input  logic [W-1:0]     ad_in,
    output logic [W-1:0]     ad_out,
    output logic             ad_oe,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    logic [W-1:0] dir_q, data_q, amode_q, od_q, addr_q;
    logic         track_q;
    logic         trk_addr, trk_wdata, trk_rdata, trk_drive;
    logic         reg_rd;
    logic [W-1:0] rd_val;

    mbp_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_addr(reg_addr),
        .wr_n(wr_n), .ad_in(ad_in), .dir_q(dir_q), .data_q(data_q),
        .amode_q(amode_q), .od_q(od_q), .track_q(track_q)
    );

    mbp_addr_latch #(.W(W)) u_alat (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .addr_q(addr_q)
    );

    // Purpose: decode which track-mode path, if any, is active.
    always_comb begin
        trk_addr  = track_q & sel_addr_out & ale;
        trk_wdata = track_q & sel_data_out & ~wr_n;
        trk_rdata = track_q & sel_data_in & ~rd_n;
        trk_drive = trk_addr | trk_wdata;
    end

    mbp_pin_drive #(.W(W)) u_pins (
        .dir_q(dir_q), .data_q(data_q), .amode_q(amode_q), .od_q(od_q),
        .addr_q(addr_q), .track_q(track_q), .trk_drive(trk_drive),
        .ad_in(ad_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Purpose: select the register addressed by a CPU read.
    always_comb begin
        reg_rd = reg_sel & ~rd_n;
        case (reg_addr)
            OFF_DIR:   rd_val = dir_q;
            OFF_DATA:  rd_val = data_q;
            OFF_PINS:  rd_val = pin_in;
            OFF_AMODE: rd_val = amode_q;
            OFF_ODRN:  rd_val = od_q;
            OFF_CTRL:  rd_val = {{(W-1){1'b0}}, track_q};
            default:   rd_val = '0;
        endcase
    end

    // Purpose: drive the bus for a register read or a track-mode data-in read.
    always_comb begin
        if (reg_rd) begin
            ad_oe  = 1'b1;
            ad_out = rd_val;
        end else if (trk_rdata) begin
            ad_oe  = 1'b1;
            ad_out = pin_in;
        end else begin
            ad_oe  = 1'b0;
            ad_out = '0;
        end
    end
endmodule

// File: rtl/mbp_chk.sv
// Module: assertion checker for mux_bus_port, attached by bind.
// Assumes register reads and track data-in reads do not overlap.
module mbp_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ale,
    input logic         rd_n,
    input logic         wr_n,
    input logic         reg_sel,
    input logic         sel_addr_out,
    input logic         sel_data_out,
    input logic         sel_data_in,
    input logic [W-1:0] ad_in,
    input logic [W-1:0] ad_out,
    input logic         ad_oe,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] amode_q,
    input logic [W-1:0] od_q,
    input logic         track_q,
    input logic [W-1:0] addr_q
);
    a_r2_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        !track_q |-> (pin_oe & ~dir_q & ~amode_q) == '0);

    a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        !track_q |-> (pin_oe & pin_out & od_q) == '0);

    a_r6_latch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> ($past(ale, 2) && !$past(ale)));

    a_r7_addr_path: assert property (@(posedge clk) disable iff (!rst_n)
        (track_q && sel_addr_out && ale) |-> (pin_oe == '1 && pin_out == ad_in));

    a_r9_data_in_path: assert property (@(posedge clk) disable iff (!rst_n)
        (track_q && sel_data_in && !rd_n && !reg_sel) |-> (ad_oe && ad_out == pin_in));

    a_r10_track_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (track_q && !(sel_addr_out && ale) && !(sel_data_out && !wr_n)) |-> pin_oe == '0);

    a_r11_bus_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!rd_n && (reg_sel || (track_q && sel_data_in))));
endmodule

bind mux_bus_port mbp_chk #(.W(W)) u_chk (.*);

// File: tb/sim_mux_bus_port.sv
module sim_mux_bus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       sel_addr_out = 1'b0, sel_data_out = 1'b0, sel_data_in = 1'b0;
    logic [7:0] ad_in = '0, pin_in = '0;
    logic [7:0] ad_out, pin_out, pin_oe;
    logic       ad_oe;

    int    tests = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    logic [7:0] m_reg [0:7];
    logic [7:0] m_addr = '0, m_shadow = '0, m_wd = '0;
    logic [2:0] m_off = '0;
    bit         m_sel = 0, m_wr_prev = 1, m_ale_prev = 0;

    always #4 clk = ~clk;

    mux_bus_port u0 (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .reg_addr(reg_addr), .sel_addr_out(sel_addr_out),
        .sel_data_out(sel_data_out), .sel_data_in(sel_data_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] = '0;
            m_addr = '0; m_shadow = '0; m_wd = '0; m_off = '0;
            m_sel = 0; m_wr_prev = 1; m_ale_prev = 0;
        end else begin
            if (wr_n && !m_wr_prev && m_sel && m_off != 3'd2)
                m_reg[m_off] = (m_off == 3'd5) ? {7'd0, m_wd[0]} : m_wd;
            if (!wr_n) begin m_wd = ad_in; m_off = reg_addr; m_sel = reg_sel; end
            m_wr_prev = wr_n;
            if (m_ale_prev && !ale) m_addr = m_shadow;
            if (ale) m_shadow = ad_in;
            m_ale_prev = ale;
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        logic [7:0] e_oe, e_out, e_ad;
        logic       e_adoe;
        if (rst_n) begin
            if (m_reg[5][0]) begin
                e_oe  = ((sel_addr_out && ale) || (sel_data_out && !wr_n)) ? 8'hFF : 8'h00;
                e_out = ad_in;
            end else begin
                for (int n = 0; n < 8; n++) begin
                    bit v, en;
                    v  = m_reg[3][n] ? m_addr[n] : m_reg[1][n];
                    en = m_reg[3][n] || m_reg[0][n];
                    if (m_reg[4][n]) begin e_oe[n] = en && !v; e_out[n] = 1'b0; end
                    else begin e_oe[n] = en; e_out[n] = v; end
                end
            end
            e_adoe = 1'b0; e_ad = '0;
            if (reg_sel && !rd_n) begin
                e_adoe = 1'b1;
                e_ad = (reg_addr == 3'd2) ? pin_in : m_reg[reg_addr];
            end else if (m_reg[5][0] && sel_data_in && !rd_n) begin
                e_adoe = 1'b1; e_ad = pin_in;
            end
            chk(cur_req, pin_oe, e_oe);
            chk(cur_req, pin_out & e_oe, e_out & e_oe);
            chk(cur_req, {7'd0, ad_oe}, {7'd0, e_adoe});
            if (e_adoe) chk(cur_req, ad_out, e_ad);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cpu_write(input logic [2:0] off, input logic [7:0] v);
        reg_sel = 1; reg_addr = off; ad_in = v; wr_n = 0;
        tick(2);
        wr_n = 1;
        tick(1);
        reg_sel = 0;
        tick(1);
    endtask

    task automatic cpu_read(input string req, input logic [2:0] off, input logic [7:0] exp);
        reg_sel = 1; reg_addr = off; rd_n = 0;
        @(negedge clk); #1;
        chk(req, ad_out, exp);
        chk(req, {7'd0, ad_oe}, 8'd1);
        tick(1);
        rd_n = 1; reg_sel = 0;
        tick(1);
    endtask

    task automatic ale_cycle(input logic [7:0] a);
        ale = 1; ad_in = a;
        tick(2);
        ale = 0; ad_in = 8'h00;
        tick(1);
    endtask

    initial begin
        tick(4);
        rst_n = 1;
        tick(1);
        // R1: reset state
        @(negedge clk); #1;
        chk("R1", pin_oe, 8'h00);
        chk("R1", {7'd0, ad_oe}, 8'd0);
        tick(1);
        cpu_read("R1", 3'd0, 8'h00);
        cpu_read("R1", 3'd5, 8'h00);

        // R4, R2: direction and data writes
        cur_req = "R4";
        cpu_write(3'd0, 8'hF0);
        cpu_write(3'd1, 8'hA5);
        cur_req = "R2";
        @(negedge clk); #1;
        chk("R2", pin_oe, 8'hF0);
        chk("R2", pin_out & 8'hF0, 8'hA0);
        tick(1);
        // R3: readback of every offset
        cur_req = "R3";
        pin_in = 8'h3C;
        cpu_read("R3", 3'd0, 8'hF0);
        cpu_read("R3", 3'd1, 8'hA5);
        cpu_read("R3", 3'd2, 8'h3C);
        cpu_read("R3", 3'd7, 8'h00);
        cpu_write(3'd2, 8'hFF);
        cpu_read("R4", 3'd1, 8'hA5);

        // R5: open drain on bits 4 and 5 (data bit5=1, bit4=0)
        cur_req = "R5";
        cpu_write(3'd4, 8'h30);
        @(negedge clk); #1;
        chk("R5", pin_oe & 8'h30, 8'h10);
        chk("R5", pin_out & 8'h10, 8'h00);
        tick(1);
        cpu_read("R3", 3'd4, 8'h30);

        // R6: address latch on the low nibble
        cur_req = "R6";
        cpu_write(3'd3, 8'h0F);
        ale = 1; ad_in = 8'h96;
        tick(2);
        @(negedge clk); #1;
        chk("R6", pin_out & pin_oe & 8'h0F, 8'h00);
        chk("R6", pin_oe & 8'h0F, 8'h0F);
        tick(1);
        ale = 0; ad_in = 8'h00;
        tick(2);
        chk("R6", pin_out & 8'h0F, 8'h06);
        ale_cycle(8'h69);
        tick(1);
        chk("R6", pin_out & 8'h0F, 8'h09);

        // R11: data-in select outside track mode
        cur_req = "R11";
        sel_data_in = 1; rd_n = 0;
        @(negedge clk); #1;
        chk("R11", {7'd0, ad_oe}, 8'd0);
        tick(1);
        rd_n = 1; sel_data_in = 0;
        tick(1);

        // R10: track mode idle
        cur_req = "R10";
        cpu_write(3'd5, 8'h01);
        tick(1);
        chk("R10", pin_oe, 8'h00);
        cpu_read("R3", 3'd5, 8'h01);

        // R7: address path
        cur_req = "R7";
        sel_addr_out = 1; ale = 1; ad_in = 8'h5A;
        @(negedge clk); #1;
        chk("R7", pin_oe, 8'hFF);
        chk("R7", pin_out, 8'h5A);
        tick(2);
        ale = 0; sel_addr_out = 0;
        tick(1);

        // R8: write data path (od bits ignored, R10)
        cur_req = "R8";
        sel_data_out = 1; ad_in = 8'hC3; wr_n = 0;
        @(negedge clk); #1;
        chk("R8", pin_oe, 8'hFF);
        chk("R8", pin_out, 8'hC3);
        tick(1);
        wr_n = 1;
        tick(1);
        chk("R10", pin_oe, 8'h00);
        sel_data_out = 0;
        tick(1);

        // R9: read data path
        cur_req = "R9";
        pin_in = 8'h81; sel_data_in = 1; rd_n = 0;
        @(negedge clk); #1;
        chk("R9", ad_out, 8'h81);
        chk("R9", {7'd0, ad_oe}, 8'd1);
        tick(1);
        rd_n = 1; sel_data_in = 0;
        tick(1);
        chk("R11", {7'd0, ad_oe}, 8'd0);

        // Leave track mode; I/O settings return
        cur_req = "R2";
        cpu_write(3'd5, 8'h00);
        tick(2);
        chk("R2", pin_oe & 8'hC0, 8'hC0);
        tick(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule